// File: doc/BRIEF.md
# Supply Rail Sequencer with Fault Shutdown

This controller owns the enable lines of five board supplies that feed a mixed-voltage clock-and-bias chip and the sensor behind it. On a start command it turns the rails on one at a time in a fixed order, with a programmable gap between steps. On a stop command it turns them off in exactly the opposite order. Each enable bit has a fixed meaning: bit 0 is the high-voltage bias supply, bit 1 the chip substrate supply, bit 2 the low-voltage supplies, bit 3 the upper and lower clock rails, and bit 4 the back-substrate supply.

The controller watches a power-good input for every rail and a watchdog kick from the communications link. A rail that stays low after its settle timeout, or a link that stops kicking, starts an emergency shutdown. This shutdown uses its own order: back-substrate first, then clock rails, then the low-voltage and substrate supplies together, and the bias supply last. The controller then stays locked until a clear command arrives. The cause of the fault is latched and shown at the ports.

The status code on `state_o` reads 0 for off, 1 for ramping up, 2 for all rails on, 3 for ramping down, 4 for emergency shutdown and 5 for locked.

Top module: `rail_seq`

## Requirements
- R1: After reset all enables are 0, `state_o` reads 0 (off), and both fault outputs are clear.
- R2: A start pulse in state 0 sets enable bit 0 at the next edge. Each further STEP_GAP cycles sets the next bit upward (bit 1, then 2, then 3, then 4). The state is 1 during the ramp and 2 once all five bits are set.
- R3: A stop pulse in state 1 or 2 clears the highest set enable bit at once. Each further STEP_GAP cycles clears the next lower bit, with the state at 3. The state returns to 0 when no bit is left. A stop pulse in state 0 changes nothing.
- R4: Each power-good input is filtered. A level change is accepted only after FILT_LEN consecutive sampled edges at the new level, so a pulse shorter than that has no effect.
- R5: A rail's filtered power-good is checked only after the rail has been enabled for PG_TIMEOUT cycles. A rail that reports good before then never faults. A filtered low on an enabled rail after the timeout is a fault.
- R6: In states 1 to 3, if WDOG_PERIOD clock edges pass without a kick pulse, that is a fault. The kick restarts the count. In states 0, 4 and 5 the watchdog is idle. `fault_wdog_o` is set when the watchdog caused the shutdown.
- R7: On a fault, the controller enters state 4 and clears enable bit 4 at the same edge. After every EMG_GAP cycles it clears bit 3, then bits 2 and 1 together, then bit 0. It then enters state 5.
- R8: `fault_rail_o` latches the power-good failures present at the edge the emergency began, one bit per rail in enable-bit order. `fault_wdog_o` latches the watchdog cause separately.
- R9: In state 5 all enables are 0 and a start pulse is ignored. A clear pulse returns the state to 0 and clears both fault outputs.
- R10: A fault takes priority over a stop in the same cycle. Start and stop pulses are ignored in state 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start power-up, one-cycle pulse |
| stop_i | input | 1 | Start orderly power-down, one-cycle pulse |
| clr_i | input | 1 | Leave the locked fault state, one-cycle pulse |
| kick_i | input | 1 | Communications watchdog kick pulse |
| pg_i | input | 5 | Raw power-good per rail |
| en_o | output | 5 | Rail enables (bit 0 bias ... bit 4 back-substrate) |
| state_o | output | 3 | Sequencer state code |
| fault_rail_o | output | 5 | Latched power-good failure per rail |
| fault_wdog_o | output | 1 | Latched watchdog expiry cause |

## Verification
The bench builds the block with a step gap of 20 cycles, an emergency gap of 6, a power-good timeout of 10, a watchdog period of 40 and a filter length of 4. With these values a full ramp, a watchdog expiry that lands on the same edge as a ramp step, and the complete emergency order all fit in a few hundred cycles. The short timeout lets the bench release power-good both before and after a rail is armed. The filter length of 4 separates a three-cycle glitch from a real drop.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  localparam int NRAIL     = 5;
  localparam int RAIL_HV   = 0;
  localparam int RAIL_SUB  = 1;
  localparam int RAIL_LV   = 2;
  localparam int RAIL_CLK  = 3;
  localparam int RAIL_BSS  = 4;
  localparam int EMG_STEPS = 4;
  localparam int ESW       = $clog2(EMG_STEPS);

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_UP   = 3'd1,
    ST_ON   = 3'd2,
    ST_DN   = 3'd3,
    ST_EMG  = 3'd4,
    ST_LOCK = 3'd5
  } seq_state_e;

  // rails still allowed on after emergency step n
  function automatic logic [NRAIL-1:0] emg_keep(input logic [ESW-1:0] step);
    logic [NRAIL-1:0] m;
    m = '1;
    m[RAIL_BSS] = 1'b0;
    if (step >= ESW'(1)) m[RAIL_CLK] = 1'b0;
    if (step >= ESW'(2)) begin
      m[RAIL_LV]  = 1'b0;
      m[RAIL_SUB] = 1'b0;
    end
    if (step >= ESW'(3)) m[RAIL_HV] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/rail_pg_check.sv
module rail_pg_check #(
  parameter int FILT_LEN   = 4,
  parameter int PG_TIMEOUT = 250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pg_i,
  output logic fail_o
);
  localparam int FCW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam int TCW = $clog2(PG_TIMEOUT + 1);
  localparam logic [FCW-1:0] F_LAST = FCW'(FILT_LEN - 1);
  localparam logic [TCW-1:0] T_END  = TCW'(PG_TIMEOUT);

  logic           filt_q;
  logic [FCW-1:0] fcnt_q;
  logic [TCW-1:0] tcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      fcnt_q <= '0;
    end else if (pg_i == filt_q) begin
      fcnt_q <= '0;
    end else if (fcnt_q == F_LAST) begin
      filt_q <= pg_i;
      fcnt_q <= '0;
    end else begin
      fcnt_q <= fcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tcnt_q <= '0;
    else if (!en_i)            tcnt_q <= '0;
    else if (tcnt_q != T_END)  tcnt_q <= tcnt_q + 1'b1;
  end

  assign fail_o = en_i && (tcnt_q == T_END) && !filt_q;
endmodule

// File: rtl/rail_comm_wdog.sv
module rail_comm_wdog #(
  parameter int WDOG_PERIOD = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int WCW = (WDOG_PERIOD > 2) ? $clog2(WDOG_PERIOD) : 1;
  localparam logic [WCW-1:0] W_LAST = WCW'(WDOG_PERIOD - 1);

  logic [WCW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!active_i || kick_i) cnt_q <= '0;
    else if (cnt_q != W_LAST)    cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = active_i && !kick_i && (cnt_q == W_LAST);
endmodule

// File: rtl/rail_seq.sv
module rail_seq
  import rail_seq_pkg::*;
#(
  parameter int STEP_GAP    = 500_000,
  parameter int EMG_GAP     = 100_000,
  parameter int PG_TIMEOUT  = 250_000,
  parameter int WDOG_PERIOD = 10_000_000,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clr_i,
  input  logic             kick_i,
  input  logic [NRAIL-1:0] pg_i,
  output logic [NRAIL-1:0] en_o,
  output logic [2:0]       state_o,
  output logic [NRAIL-1:0] fault_rail_o,
  output logic             fault_wdog_o
);
  localparam int GMAX = (STEP_GAP > EMG_GAP) ? STEP_GAP : EMG_GAP;
  localparam int GCW  = (GMAX > 2) ? $clog2(GMAX) : 1;
  localparam logic [GCW-1:0] STEP_LAST = GCW'(STEP_GAP - 1);
  localparam logic [GCW-1:0] EMG_LAST  = GCW'(EMG_GAP - 1);
  localparam logic [ESW-1:0] ESTEP_END = ESW'(EMG_STEPS - 1);

  seq_state_e       state_q;
  logic [NRAIL-1:0] en_q, pg_fail, frail_q;
  logic [GCW-1:0]   gap_q;
  logic [ESW-1:0]   estep_q;
  logic             fwd_q, wd_exp, fault, wd_active;
  logic [NRAIL-1:0] en_up, en_dn;

  for (genvar k = 0; k < NRAIL; k++) begin : g_rail
    rail_pg_check #(.FILT_LEN(FILT_LEN), .PG_TIMEOUT(PG_TIMEOUT)) u_chk (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_q[k]),
      .pg_i  (pg_i[k]),
      .fail_o(pg_fail[k])
    );
  end

  assign wd_active = (state_q == ST_UP) || (state_q == ST_ON) || (state_q == ST_DN);

  rail_comm_wdog #(.WDOG_PERIOD(WDOG_PERIOD)) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(wd_active),
    .kick_i  (kick_i),
    .expire_o(wd_exp)
  );

  assign fault = (|pg_fail) || wd_exp;
  assign en_up = {en_q[NRAIL-2:0], 1'b1};
  assign en_dn = en_q >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      en_q    <= '0;
      gap_q   <= '0;
      estep_q <= '0;
      frail_q <= '0;
      fwd_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: if (start_i) begin
          state_q <= ST_UP;
          en_q    <= NRAIL'(1);
          gap_q   <= '0;
        end
        ST_UP, ST_ON, ST_DN: begin
          if (fault) begin
            state_q <= ST_EMG;
            en_q    <= en_q & emg_keep('0);
            estep_q <= ESW'(1);
            gap_q   <= '0;
            frail_q <= pg_fail;
            fwd_q   <= wd_exp;
          end else if (stop_i && state_q != ST_DN) begin
            en_q    <= en_dn;
            state_q <= (en_dn == '0) ? ST_OFF : ST_DN;
            gap_q   <= '0;
          end else if (state_q != ST_ON) begin
            if (gap_q == STEP_LAST) begin
              gap_q <= '0;
              if (state_q == ST_UP) begin
                en_q <= en_up;
                if (en_q[NRAIL-2]) state_q <= ST_ON;
              end else begin
                en_q <= en_dn;
                if (!en_q[1]) state_q <= ST_OFF;
              end
            end else begin
              gap_q <= gap_q + 1'b1;
            end
          end
        end
        ST_EMG: begin
          if (gap_q == EMG_LAST) begin
            gap_q <= '0;
            en_q  <= en_q & emg_keep(estep_q);
            if (estep_q == ESTEP_END) state_q <= ST_LOCK;
            else                      estep_q <= estep_q + 1'b1;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_LOCK: if (clr_i) begin
          state_q <= ST_OFF;
          frail_q <= '0;
          fwd_q   <= 1'b0;
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign en_o         = en_q;
  assign state_o      = state_q;
  assign fault_rail_o = frail_q;
  assign fault_wdog_o = fwd_q;
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk
  import rail_seq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NRAIL-1:0] en_o,
  input logic [2:0]       state_o,
  input logic             fault_wdog_o
);
  AST_OFF_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_OFF |-> en_o == '0); // R1
  AST_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o & (en_o + 1'b1)) == '0); // R2
  AST_ONE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(en_o) <= $countones($past(en_o)) + 1); // R2
  AST_DN_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_DN |=> (en_o & ~$past(en_o)) == '0); // R3
  AST_EMG_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_EMG |=> (en_o & ~$past(en_o)) == '0); // R7
  AST_EMG_BSS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_o == ST_EMG) |-> !en_o[RAIL_BSS]); // R7
  AST_WD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_wdog_o) |-> state_o == ST_EMG); // R6
  AST_LOCK_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_LOCK |-> en_o == '0); // R9
endmodule

bind rail_seq rail_seq_chk u_rail_seq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_o        (en_o),
  .state_o     (state_o),
  .fault_wdog_o(fault_wdog_o)
);

// File: tb/tb_rail_seq.sv
module tb_rail_seq;
  localparam int STEP = 20;
  localparam int EMG  = 6;
  localparam int TO   = 10;
  localparam int WD   = 40;
  localparam int FL   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, clr_i = 1'b0, kick_i = 1'b0;
  logic [4:0] kill = '0, glit = '0;
  logic [4:0] pg_i, en_o, fault_rail_o;
  logic [2:0] state_o;
  logic fault_wdog_o;
  logic auto_kick = 1'b0;
  int vectors = 0, fails = 0, kc = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  assign pg_i = (en_o & ~kill) ^ glit;

  rail_seq #(.STEP_GAP(STEP), .EMG_GAP(EMG), .PG_TIMEOUT(TO),
             .WDOG_PERIOD(WD), .FILT_LEN(FL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .stop_i(stop_i),
    .clr_i(clr_i), .kick_i(kick_i), .pg_i(pg_i), .en_o(en_o),
    .state_o(state_o), .fault_rail_o(fault_rail_o), .fault_wdog_o(fault_wdog_o));

  always @(negedge clk) begin
    kick_i <= auto_kick && (kc % 8 == 0);
    kc++;
  end

  // behavioural reference
  int m_state, m_gap, m_estep, m_wc;
  logic [4:0] m_en, m_frail;
  logic m_fwd;
  logic m_filt[5];
  int m_fc[5], m_tc[5];

  function automatic logic [4:0] keep_after(int step);
    case (step)
      0: return 5'b01111;
      1: return 5'b00111;
      2: return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [4:0] pf;
    logic act, wx;
    if (!rst_n) begin
      m_state = 0; m_gap = 0; m_estep = 0; m_wc = 0;
      m_en = 0; m_frail = 0; m_fwd = 0;
      for (int k = 0; k < 5; k++) begin m_filt[k] = 0; m_fc[k] = 0; m_tc[k] = 0; end
    end else begin
      pf = 0;
      for (int k = 0; k < 5; k++)
        if (m_en[k] && m_tc[k] == TO && !m_filt[k]) pf[k] = 1;
      act = (m_state >= 1 && m_state <= 3);
      wx = act && !kick_i && m_wc == WD - 1;
      for (int k = 0; k < 5; k++) begin
        if (pg_i[k] == m_filt[k]) m_fc[k] = 0;
        else if (m_fc[k] == FL - 1) begin m_filt[k] = pg_i[k]; m_fc[k] = 0; end
        else m_fc[k]++;
        if (!m_en[k]) m_tc[k] = 0;
        else if (m_tc[k] < TO) m_tc[k]++;
      end
      if (!act || kick_i) m_wc = 0;
      else if (m_wc < WD - 1) m_wc++;
      case (m_state)
        0: if (start_i) begin m_state = 1; m_en = 5'b00001; m_gap = 0; end
        1, 2, 3: begin
          if (pf != 0 || wx) begin
            m_frail = pf; m_fwd = wx; m_en = m_en & keep_after(0);
            m_estep = 1; m_gap = 0; m_state = 4;
          end else if (stop_i && m_state != 3) begin
            m_en = m_en >> 1; m_gap = 0;
            m_state = (m_en == 0) ? 0 : 3;
          end else if (m_state != 2) begin
            if (m_gap == STEP - 1) begin
              m_gap = 0;
              if (m_state == 1) begin
                m_en = {m_en[3:0], 1'b1};
                if (m_en == 5'b11111) m_state = 2;
              end else begin
                m_en = m_en >> 1;
                if (m_en == 0) m_state = 0;
              end
            end else m_gap++;
          end
        end
        4: begin
          if (m_gap == EMG - 1) begin
            m_gap = 0; m_en = m_en & keep_after(m_estep);
            if (m_estep == 3) m_state = 5; else m_estep++;
          end else m_gap++;
        end
        5: if (clr_i) begin m_state = 0; m_frail = 0; m_fwd = 0; end
        default: m_state = 0;
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rst_n)
      chk(cur_req, {18'd0, en_o, state_o, fault_rail_o, fault_wdog_o},
          {18'd0, m_en, m_state[2:0], m_frail, m_fwd});

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: start_i = 1'b1;
      1: stop_i = 1'b1;
      default: clr_i = 1'b1;
    endcase
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    cur_req = "R1";
    chk("R1", {en_o, state_o, fault_rail_o, fault_wdog_o}, 0);

    cur_req = "R3";
    pulse(1); wait_n(2);
    chk("R3", {en_o, state_o}, 0);

    cur_req = "R2";
    auto_kick = 1'b1;
    pulse(0); wait_n(100);
    chk("R2", {en_o, state_o}, {5'b11111, 3'd2});

    cur_req = "R4";
    glit = 5'b00010; wait_n(3); glit = 0; wait_n(10);
    chk("R4", state_o, 2);

    cur_req = "R3";
    pulse(1); wait_n(100);
    chk("R3", {en_o, state_o}, 0);

    cur_req = "R5";
    kill = 5'b00001;
    pulse(0); wait_n(4); kill = 0; wait_n(10);
    chk("R5", state_o, 1);
    wait_n(100);
    chk("R5", state_o, 2);

    cur_req = "R7";
    kill = 5'b00100; wait_n(40);
    chk("R8", {fault_rail_o, fault_wdog_o, state_o}, {5'b00100, 1'b0, 3'd5});
    kill = 0;

    cur_req = "R9";
    pulse(0); wait_n(3);
    chk("R9", {en_o, state_o}, {5'b0, 3'd5});
    pulse(2); wait_n(1);
    chk("R9", {state_o, fault_rail_o, fault_wdog_o}, 0);

    cur_req = "R6";
    auto_kick = 1'b0;
    pulse(0); wait_n(41);
    chk("R6", {en_o, state_o, fault_wdog_o}, {5'b00011, 3'd4, 1'b1});
    cur_req = "R10";
    pulse(0); pulse(1); wait_n(8);
    chk("R7", {en_o, state_o}, {5'b00001, 3'd4});
    wait_n(10);
    chk("R8", {en_o, state_o, fault_rail_o, fault_wdog_o}, {5'b0, 3'd5, 5'b0, 1'b1});
    pulse(2); wait_n(5);
    finish_run();
  end
endmodule